// File: doc/BRIEF.md
# Error Pin Assertion Controller

This block drives the active-low error output of a safety error aggregator. It watches a vector of raw error flags together with a mask that says which flags may affect the pin. When any unmasked flag is set, the pin is pulled low. It stays low for at least a programmable number of clock cycles. The pin goes high again only after three things have happened: the interval has run out, software has cleared every pending flag, and a CLEAR strobe has arrived after that cleanup.

A four-state machine (RESET, IDLE, ERROR, WAIT) controls the pin. A down-counter times the minimum interval and is loaded once, when the pin first goes low. A CLEAR that arrives while flags are still pending is thrown away. A CLEAR that arrives with no flags pending, before the interval has run out, is held in the WAIT state. If a new flag shows up in WAIT, the machine returns to ERROR and needs a fresh CLEAR, but the counter is not reloaded. A 4-bit mode key written through the configuration port can force the pin low from software. The status output reads 1 while the pin is released.

Power-on reset is asynchronous and leaves the pin low until the module is enabled. A synchronous soft reset returns the machine to IDLE.

Top module: `errpin_ctrl`

## Requirements
- R1: An event counts as pending only when bit i of `evtRaw` and bit i of `evtInfl` are both 1. A raw flag whose mask bit is 0 never changes the pin.
- R2: In IDLE with `modEnable` high, a pending event drives `errPinN` low from the next rising clock edge. On that same edge the interval counter loads the current preload value P.
- R3: Once asserted, the pin stays low for at least P+1 clock cycles, whatever CLEAR strobes arrive. Further events in ERROR do not reload the counter; it keeps decrementing by one per cycle down to zero.
- R4: A CLEAR received in ERROR with no pending event, while the counter is nonzero, moves the machine to WAIT. The pin then rises on the clock edge after the counter has reached zero, with no further CLEAR.
- R5: A CLEAR received in ERROR while any event is pending is discarded: the machine stays in ERROR and the pin stays low.
- R6: A pending event seen in WAIT returns the machine to ERROR on the next edge without reloading the counter. A fresh CLEAR is then needed to release the pin.
- R7: In ERROR with the counter at zero and no event pending, the pin is released on the edge after a CLEAR strobe, and not before one arrives.
- R8: While `porRstN` is low the pin is low, the mode key is 0x0 and the preload is PRELOAD_RST. After power-on reset is released the pin stays low until a clock edge with `modEnable` high. `softRst` high at a clock edge puts the machine in IDLE and clears the counter.
- R9: A write through `cfgWrite` stores `wrKey` and `wrPreload`. While the stored key is 0xA the pin is forced low. Any other key value, including 0x0, gives normal operation.
- R10: `pinStatus` is 1 while the pin is released (high) and 0 while it is asserted (low).
- R11: In IDLE with `modEnable` low, pending events are ignored and the pin stays high. In ERROR and WAIT the pending condition is evaluated whatever the value of `modEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| softRst | input | 1 | Synchronous global soft reset, active high |
| modEnable | input | 1 | Module global enable |
| cfgWrite | input | 1 | Write strobe for the key and preload fields |
| wrKey | input | 4 | Mode key (0x0 normal, 0xA force error) |
| wrPreload | input | CNT_W | Minimum interval preload, in cycles |
| clearStrobe | input | 1 | Single-cycle CLEAR command |
| evtRaw | input | NUM_EVT | Raw error event flags |
| evtInfl | input | NUM_EVT | Per-event pin influence enable |
| errPinN | output | 1 | Error pin, active low |
| pinStatus | output | 1 | 1 when the pin is released |

## Verification
The bench goes after the orderings that decide when the pin may rise. The first is a CLEAR that arrives early, during the interval. A design that forgot it would hold the pin low for ever; one that acted on it at once would cut the interval short. The second is a CLEAR that arrives while events are still pending: a design that stored it would release the pin without a later CLEAR. The third is an event that comes back during WAIT: a design that reloaded the counter would stretch the low time, and one that stayed in WAIT would release without a new CLEAR. Masked events, events with the module disabled, forced mode and both resets are driven in directed runs and again inside a long seeded random run.

// File: rtl/errpin_pkg.sv
package errpin_pkg;

  localparam int KEY_W = 4;
  localparam logic [KEY_W-1:0] KEY_NORMAL = 4'h0;
  localparam logic [KEY_W-1:0] KEY_FORCE  = 4'hA;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_IDLE  = 2'd1,
    ST_ERROR = 2'd2,
    ST_WAIT  = 2'd3
  } pin_state_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCnt;
    logic runCnt;
    logic clrCnt;
    logic assertPin;
  } pin_ctl_t;

endpackage

// File: rtl/errpin_interval_cnt.sv
module errpin_interval_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             load,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             expired
);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (run && (count != '0)) begin
      count <= count - CNT_W'(1);
    end
  end

  assign expired = (count == '0);

endmodule

// File: rtl/errpin_ctrl_dp.sv
module errpin_ctrl_dp
  import errpin_pkg::*;
#(
  parameter int NUM_EVT     = 8,
  parameter int CNT_W       = 16,
  parameter int PRELOAD_RST = 4
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               cfgWrite,
  input  logic [KEY_W-1:0]   wrKey,
  input  logic [CNT_W-1:0]   wrPreload,
  input  logic [NUM_EVT-1:0] evtRaw,
  input  logic [NUM_EVT-1:0] evtInfl,
  input  pin_ctl_t           ctl,
  output logic               pending,
  output logic               expired,
  output logic [CNT_W-1:0]   count,
  output logic               errPinN,
  output logic               pinStatus
);

  localparam logic [CNT_W-1:0] PRELOAD_INIT = CNT_W'(PRELOAD_RST);

  logic [KEY_W-1:0]   keyReg;
  logic [CNT_W-1:0]   preloadReg;
  logic [NUM_EVT-1:0] evtLive;
  logic               forceMode;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      keyReg     <= KEY_NORMAL;
      preloadReg <= PRELOAD_INIT;
    end else if (cfgWrite) begin
      keyReg     <= wrKey;
      preloadReg <= wrPreload;
    end
  end

  // per-event gating of raw flags by the influence mask
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign evtLive[i] = evtRaw[i] & evtInfl[i];
  end

  assign pending = |evtLive;

  errpin_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .porRstN (porRstN),
    .load    (ctl.loadCnt),
    .run     (ctl.runCnt),
    .clr     (ctl.clrCnt),
    .loadVal (preloadReg),
    .count   (count),
    .expired (expired)
  );

  assign forceMode = (keyReg == KEY_FORCE);
  assign errPinN   = ~(ctl.assertPin | forceMode);
  assign pinStatus = errPinN;

endmodule

// File: rtl/errpin_ctrl_fsm.sv
module errpin_ctrl_fsm
  import errpin_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       softRst,
  input  logic       modEnable,
  input  logic       clearStrobe,
  input  logic       pending,
  input  logic       expired,
  output pin_ctl_t   ctl,
  output pin_state_e state
);

  pin_state_e nextState;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state <= ST_RESET;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState     = state;
    ctl.loadCnt   = 1'b0;
    ctl.runCnt    = 1'b0;
    ctl.clrCnt    = 1'b0;
    ctl.assertPin = (state != ST_IDLE);
    if (softRst) begin
      nextState  = ST_IDLE;
      ctl.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_RESET: begin
          if (modEnable) nextState = ST_IDLE;
        end
        ST_IDLE: begin
          if (modEnable && pending) begin
            nextState   = ST_ERROR;
            ctl.loadCnt = 1'b1;
          end
        end
        ST_ERROR: begin
          ctl.runCnt = 1'b1;
          // a CLEAR only counts once every event has been cleared
          if (clearStrobe && !pending) begin
            nextState = expired ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          ctl.runCnt = 1'b1;
          if (pending) begin
            nextState = ST_ERROR;
          end else if (expired) begin
            nextState = ST_IDLE;
          end
        end
        default: nextState = ST_RESET;
      endcase
    end
  end

endmodule

// File: rtl/errpin_ctrl.sv
module errpin_ctrl
  import errpin_pkg::*;
#(
  parameter int NUM_EVT     = 8,
  parameter int CNT_W       = 16,
  parameter int PRELOAD_RST = 4
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               softRst,
  input  logic               modEnable,
  input  logic               cfgWrite,
  input  logic [3:0]         wrKey,
  input  logic [CNT_W-1:0]   wrPreload,
  input  logic               clearStrobe,
  input  logic [NUM_EVT-1:0] evtRaw,
  input  logic [NUM_EVT-1:0] evtInfl,
  output logic               errPinN,
  output logic               pinStatus
);

  pin_ctl_t         ctlBus;
  pin_state_e       ctrlState;
  logic             pendingEvt;
  logic             cntExpired;
  logic [CNT_W-1:0] cntVal;

  errpin_ctrl_fsm u_fsm (
    .clk         (clk),
    .porRstN     (porRstN),
    .softRst     (softRst),
    .modEnable   (modEnable),
    .clearStrobe (clearStrobe),
    .pending     (pendingEvt),
    .expired     (cntExpired),
    .ctl         (ctlBus),
    .state       (ctrlState)
  );

  errpin_ctrl_dp #(
    .NUM_EVT     (NUM_EVT),
    .CNT_W       (CNT_W),
    .PRELOAD_RST (PRELOAD_RST)
  ) u_dp (
    .clk       (clk),
    .porRstN   (porRstN),
    .cfgWrite  (cfgWrite),
    .wrKey     (wrKey),
    .wrPreload (wrPreload),
    .evtRaw    (evtRaw),
    .evtInfl   (evtInfl),
    .ctl       (ctlBus),
    .pending   (pendingEvt),
    .expired   (cntExpired),
    .count     (cntVal),
    .errPinN   (errPinN),
    .pinStatus (pinStatus)
  );

endmodule

// File: rtl/errpin_ctrl_chk.sv
module errpin_ctrl_chk
  import errpin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             porRstN,
  input logic             softRst,
  input logic             modEnable,
  input logic             clearStrobe,
  input logic             pending,
  input pin_state_e       state,
  input logic [CNT_W-1:0] count,
  input logic             errPinN
);

  // R2: pending event in enabled IDLE pulls the pin low next cycle
  p_assert_on_event_r2: assert property (@(posedge clk) disable iff (!porRstN)
    (state == ST_IDLE && modEnable && pending && !softRst) |=> !errPinN);

  // R3: a running interval is never reloaded, only decremented
  p_no_reload_r3: assert property (@(posedge clk) disable iff (!porRstN)
    ((state == ST_ERROR || state == ST_WAIT) && count != '0 && !softRst)
      |=> (count == $past(count) - CNT_W'(1)));

  // R3: pin held while the interval runs
  p_hold_low_r3: assert property (@(posedge clk) disable iff (!porRstN)
    ((state == ST_ERROR || state == ST_WAIT) && count != '0 && !softRst) |=> !errPinN);

  // R5: CLEAR with events pending is discarded
  p_clear_pending_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (state == ST_ERROR && clearStrobe && pending && !softRst) |=> state == ST_ERROR);

  // R6: an event in WAIT returns to ERROR
  p_wait_reerror_r6: assert property (@(posedge clk) disable iff (!porRstN)
    (state == ST_WAIT && pending && !softRst) |=> state == ST_ERROR);

  // R8: soft reset lands in IDLE with the counter cleared
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!porRstN)
    softRst |=> (state == ST_IDLE && count == '0));

  // R11: disabled IDLE ignores events
  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!porRstN)
    (state == ST_IDLE && !modEnable && !softRst) |=> state == ST_IDLE);

endmodule

bind errpin_ctrl errpin_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .porRstN     (porRstN),
  .softRst     (softRst),
  .modEnable   (modEnable),
  .clearStrobe (clearStrobe),
  .pending     (pendingEvt),
  .state       (ctrlState),
  .count       (cntVal),
  .errPinN     (errPinN)
);

// File: tb/errpin_ctrl_test.sv
`timescale 1ns/1ps
module errpin_ctrl_test;

  localparam int NUM_EVT     = 8;
  localparam int CNT_W       = 16;
  localparam int PRELOAD_RST = 4;

  localparam int M_RESET = 0, M_IDLE = 1, M_ERROR = 2, M_WAIT = 3;

  logic               clk = 1'b0;
  logic               porRstN = 1'b0;
  logic               softRst = 1'b0;
  logic               modEnable = 1'b0;
  logic               cfgWrite = 1'b0;
  logic [3:0]         wrKey = 4'h0;
  logic [CNT_W-1:0]   wrPreload = '0;
  logic               clearStrobe = 1'b0;
  logic [NUM_EVT-1:0] evtRaw = '0;
  logic [NUM_EVT-1:0] evtInfl = '0;
  logic               errPinN;
  logic               pinStatus;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model state
  int         mState;
  int         mCnt;
  logic [3:0] mKey;
  int         mPre;

  always #4 clk = ~clk;

  errpin_ctrl #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .PRELOAD_RST(PRELOAD_RST)) uut (
    .clk(clk), .porRstN(porRstN), .softRst(softRst), .modEnable(modEnable),
    .cfgWrite(cfgWrite), .wrKey(wrKey), .wrPreload(wrPreload),
    .clearStrobe(clearStrobe), .evtRaw(evtRaw), .evtInfl(evtInfl),
    .errPinN(errPinN), .pinStatus(pinStatus)
  );

  function automatic logic expPin();
    return !((mState != M_IDLE) || (mKey == 4'hA));
  endfunction

  task automatic modelReset();
    mState = M_RESET; mCnt = 0; mKey = 4'h0; mPre = PRELOAD_RST;
  endtask

  task automatic modelTick();
    int  ns, nc;
    bit  pend;
    if (!porRstN) begin modelReset(); return; end
    pend = |(evtRaw & evtInfl);
    ns = mState; nc = mCnt;
    if (softRst) begin
      ns = M_IDLE; nc = 0;
    end else begin
      case (mState)
        M_RESET: if (modEnable) ns = M_IDLE;
        M_IDLE:  if (modEnable && pend) begin ns = M_ERROR; nc = mPre; end
        M_ERROR: begin
          if (mCnt > 0) nc = mCnt - 1;
          if (clearStrobe && !pend) ns = (mCnt == 0) ? M_IDLE : M_WAIT;
        end
        default: begin
          if (mCnt > 0) nc = mCnt - 1;
          if (pend) ns = M_ERROR;
          else if (mCnt == 0) ns = M_IDLE;
        end
      endcase
    end
    if (cfgWrite) begin mKey = wrKey; mPre = int'(wrPreload); end
    mState = ns; mCnt = nc;
  endtask

  task automatic check(string tag);
    logic e;
    e = expPin();
    vectors++;
    if (errPinN !== e) begin
      fails++;
      $display("FAIL %s errPinN actual=%b expected=%b t=%0t", tag, errPinN, e, $time);
    end
    vectors++;
    if (pinStatus !== e) begin
      fails++;
      $display("FAIL R10 (%s) pinStatus actual=%b expected=%b t=%0t", tag, pinStatus, e, $time);
    end
  endtask

  task automatic checkVal(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelTick();
    @(negedge clk);
    check(tag);
  endtask

  task automatic pulseClear(string tag);
    clearStrobe = 1'b1; step(tag); clearStrobe = 1'b0;
  endtask

  initial begin
    int lowCnt;
    void'($urandom(32'd20240611));
    modelReset();
    @(negedge clk);
    check("R8 por low");
    @(negedge clk);
    check("R8 por low");
    porRstN = 1'b1;
    step("R8 held until enable");
    step("R8 held until enable");
    modEnable = 1'b1;
    step("R8 release on enable");

    // preload 5, normal key
    cfgWrite = 1'b1; wrKey = 4'h0; wrPreload = 16'd5;
    step("R9 cfg write"); cfgWrite = 1'b0;

    // R1: masked event
    evtRaw = 8'h01; evtInfl = 8'h00;
    repeat (3) step("R1 masked event ignored");
    // R11: disabled IDLE
    modEnable = 1'b0; evtInfl = 8'h01;
    repeat (3) step("R11 disabled ignores event");
    modEnable = 1'b1;
    step("R2 assert on pending");
    lowCnt = (errPinN == 1'b0) ? 1 : 0;
    // R4: early clear remembered
    evtRaw = 8'h00;
    pulseClear("R4 early clear");
    if (!errPinN) lowCnt++;
    for (int i = 0; i < 10; i++) begin
      step("R4 wait for interval");
      if (!errPinN) lowCnt++;
    end
    checkVal("R3 low duration P+1", lowCnt, 6);

    // R5: clear while pending is discarded
    evtRaw = 8'h01; evtInfl = 8'h03;
    step("R2 assert again");
    for (int i = 0; i < 10; i++) begin
      evtRaw = (i % 2 == 0) ? 8'h03 : 8'h01;   // R3 more events, no reload
      pulseClear("R5 clear with pending");
    end
    evtRaw = 8'h00;
    repeat (3) step("R7 no release without clear");
    pulseClear("R7 clear after expiry");

    // R6: event returns during WAIT
    cfgWrite = 1'b1; wrPreload = 16'd8; step("R9 cfg write"); cfgWrite = 1'b0;
    evtRaw = 8'h02;
    step("R2 assert");
    evtRaw = 8'h00;
    pulseClear("R4 enter wait");
    step("R6 waiting");
    evtRaw = 8'h02;
    step("R6 back to error");
    evtRaw = 8'h00;
    repeat (12) step("R6 fresh clear needed");
    pulseClear("R6 fresh clear");
    step("R6 released");

    // R9: forced mode
    cfgWrite = 1'b1; wrKey = 4'hA; step("R9 force key"); cfgWrite = 1'b0;
    repeat (2) step("R9 forced low");
    cfgWrite = 1'b1; wrKey = 4'h5; step("R9 other key normal"); cfgWrite = 1'b0;
    step("R9 other key normal");

    // R8: soft reset from ERROR
    evtRaw = 8'h01;
    step("R2 assert");
    evtRaw = 8'h00; softRst = 1'b1;
    step("R8 soft reset to idle"); softRst = 1'b0;
    step("R8 idle after soft reset");

    // seeded random run
    for (int n = 0; n < 6000; n++) begin
      if ($urandom % 4 == 0) evtRaw = ($urandom % 3 == 0) ? NUM_EVT'($urandom) : '0;
      if ($urandom % 40 == 0) evtInfl = NUM_EVT'($urandom);
      clearStrobe = ($urandom % 5 == 0);
      modEnable   = ($urandom % 20 != 0);
      softRst     = ($urandom % 500 == 0);
      cfgWrite    = ($urandom % 60 == 0);
      case ($urandom % 4)
        0: wrKey = 4'hA;
        1: wrKey = 4'($urandom);
        default: wrKey = 4'h0;
      endcase
      wrPreload = CNT_W'($urandom % 13);
      step("R2 random");
    end
    clearStrobe = 1'b0; softRst = 1'b0; cfgWrite = 1'b0;

    // asynchronous power-on reset mid-run
    evtRaw = 8'h01; evtInfl = 8'h01; modEnable = 1'b1;
    step("R2 before por");
    porRstN = 1'b0;
    #1 modelReset();
    check("R8 async por");
    @(negedge clk);
    porRstN = 1'b1;
    evtRaw = 8'h00;
    step("R8 after por");
    step("R8 after por");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule